// File: doc/BRIEF.md
# Dual-Target Maskable Interrupt Bank

This block collects up to 32 interrupt sources into one bank. Each hardware request line passes through a synchroniser. A register of software-forced requests is ORed onto the synchronised lines, which lets software retrigger a source or withdraw the request at end of service. The combined pending vector is then gated by two independent enable masks. One mask belongs to the main CPU and the other to a coprocessor. A per-target class word decides, bit by bit, whether an enabled request drives that target's normal interrupt output or its fast interrupt output.

Software reaches the bank over a simple two-phase, APB-like register bus with word-aligned 32-bit accesses. Enable masks and forced requests can be read at their own offsets. They can only be changed through set and clear alias addresses, so a single write updates selected bits without a read-modify-write. Software saves and restores a mask by reading it, issuing a clear-all, and then writing the saved word to the set alias. A read-only word shows which fast-class requests are currently offered to the CPU.

Top module: `irq_gate_bank`

## Requirements
- R1: While `rst` is high every register, `prdata` and all four interrupt outputs go to zero. After reset every readable word reads 0.
- R2: The CPU enable mask reads at offset 0x20. Writing to 0x24 sets each bit where the data is 1. Writing to 0x28 clears each bit where the data is 1. Bits written as 0 keep their value.
- R3: The coprocessor enable mask reads at 0x30. Its set alias is 0x34 and its clear alias is 0x38, with the same one-bits-act rule as R2.
- R4: The forced-request word reads at 0x14, is set through 0x18 and is cleared through 0x1C. A set forced bit makes that source pending with no hardware request, and clearing it withdraws the request.
- R5: The CPU class word at 0x2C and the coprocessor class word at 0x3C are plain read/write. Class bit 0 routes a source to the normal output (`*_irq`), and class bit 1 routes it to the fast output (`*_fiq`).
- R6: A hardware request on `hw_req` is captured at a rising edge. It reaches the outputs on the second rising edge after that capture, so the outputs change after the third edge counted from the sampling edge. Pending is the OR of the synchronised lines and the forced word.
- R7: For each target, the irq output is the OR over sources of (pending AND enable AND NOT class), and the fiq output is the OR of (pending AND enable AND class). Both outputs are registered, one edge after their inputs.
- R8: Offset 0x08 reads pending AND CPU-enable AND CPU-class. This is the set of fast-class requests offered to the CPU.
- R9: Reads of the alias offsets (0x18, 0x1C, 0x24, 0x28, 0x34, 0x38) and of undefined offsets return 0. Writes to the readback offsets 0x08, 0x14, 0x20 and 0x30, and to undefined offsets, change nothing.
- R10: An access completes on the edge where `psel` and `penable` are both high. Read data appears on `prdata` after that edge and holds until the next read completes.
- R11: Writing all ones to an enable clear alias disables every source in one access. A following write of a saved word to the set alias restores exactly that mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bank selected for an access |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| hw_req | input | 32 | Asynchronous level request lines |
| cpu_irq | output | 1 | CPU normal interrupt |
| cpu_fiq | output | 1 | CPU fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
The bench sets and clears overlapping bit groups through the aliases. A design that wrote the data straight into a mask, instead of ORing or masking it, would lose bits that were set earlier. It writes directly to readback offsets and reads alias offsets. A decoder that treated these as ordinary registers would corrupt a mask or return stale data. It chooses source bits so that one target gets an irq from a source while the other target gets a fiq from another, and it toggles forced requests against the fast status word. A swapped class polarity or a crossed target would then show at once. Checks placed cycle by cycle after a hardware request expose a synchroniser with one stage too few or too many.

// File: rtl/igb_pkg.sv
package igb_pkg;
  localparam int ADDR_W  = 8;
  localparam int NUM_TGT = 2;
  localparam int TGT_CPU = 0;
  localparam int TGT_COP = 1;

  localparam logic [ADDR_W-1:0] OFF_FIQ_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FRC      = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_FRC_SET  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_FRC_CLR  = 8'h1C;

  // Per-target block: mask at base, set at +4, clear at +8, class at +C
  localparam logic [ADDR_W-1:0] STEP_SET = 8'h04;
  localparam logic [ADDR_W-1:0] STEP_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] STEP_CLS = 8'h0C;

  function automatic logic [ADDR_W-1:0] tgt_base(input int t);
    return (t == TGT_CPU) ? 8'h20 : 8'h30;
  endfunction
endpackage

// File: rtl/igb_sync.sv
module igb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/igb_regs.sv
module igb_regs
  import igb_pkg::*;
#(
  parameter int W  = 32,
  parameter int NT = NUM_TGT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [W-1:0]         pwdata,
  input  logic [W-1:0]         fiq_stat,
  output logic [W-1:0]         prdata,
  output logic [W-1:0]         frc_q,
  output logic [NT-1:0][W-1:0] en_q,
  output logic [NT-1:0][W-1:0] cls_q
);
  logic              wr_acc;
  logic              rd_acc;
  logic [ADDR_W-1:0] word;
  logic [W-1:0]      rd_mux;

  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;
  assign word   = {paddr[ADDR_W-1:2], 2'b00};

  // Forced requests: alias-only updates
  always_ff @(posedge clk) begin
    if (rst) begin
      frc_q <= '0;
    end else if (wr_acc) begin
      if (word == OFF_FRC_SET) frc_q <= frc_q | pwdata;
      else if (word == OFF_FRC_CLR) frc_q <= frc_q & ~pwdata;
    end
  end

  // One enable mask and one class word per target
  for (genvar t = 0; t < NT; t++) begin : g_tgt
    localparam logic [ADDR_W-1:0] BASE = tgt_base(t);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[t] <= '0;
      end else if (wr_acc) begin
        if (word == BASE + STEP_SET) en_q[t] <= en_q[t] | pwdata;
        else if (word == BASE + STEP_CLR) en_q[t] <= en_q[t] & ~pwdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cls_q[t] <= '0;
      end else if (wr_acc && word == BASE + STEP_CLS) begin
        cls_q[t] <= pwdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (word == OFF_FIQ_STAT) rd_mux = fiq_stat;
    if (word == OFF_FRC) rd_mux = frc_q;
    for (int t = 0; t < NT; t++) begin
      if (word == tgt_base(t)) rd_mux = en_q[t];
      if (word == tgt_base(t) + STEP_CLS) rd_mux = cls_q[t];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (rd_acc) begin
      prdata <= rd_mux;
    end
  end
endmodule

// File: rtl/igb_route.sv
module igb_route #(
  parameter int W  = 32,
  parameter int NT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         pend,
  input  logic [NT-1:0][W-1:0] en_q,
  input  logic [NT-1:0][W-1:0] cls_q,
  output logic [NT-1:0]        irq_o,
  output logic [NT-1:0]        fiq_o
);
  for (genvar t = 0; t < NT; t++) begin : g_tgt
    logic [W-1:0] live;
    assign live = pend & en_q[t];

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_o[t] <= 1'b0;
        fiq_o[t] <= 1'b0;
      end else begin
        irq_o[t] <= |(live & ~cls_q[t]);
        fiq_o[t] <= |(live & cls_q[t]);
      end
    end
  end
endmodule

// File: rtl/irq_gate_bank.sv
module irq_gate_bank
  import igb_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [NUM_SRC-1:0] pwdata,
  output logic [NUM_SRC-1:0] prdata,
  input  logic [NUM_SRC-1:0] hw_req,
  output logic               cpu_irq,
  output logic               cpu_fiq,
  output logic               cop_irq,
  output logic               cop_fiq
);
  localparam int NT = NUM_TGT;

  logic [NUM_SRC-1:0]         sync_vec;
  logic [NUM_SRC-1:0]         frc_vec;
  logic [NUM_SRC-1:0]         pend_vec;
  logic [NUM_SRC-1:0]         fiq_stat;
  logic [NT-1:0][NUM_SRC-1:0] en_vec;
  logic [NT-1:0][NUM_SRC-1:0] cls_vec;
  logic [NT-1:0]              irq_vec;
  logic [NT-1:0]              fiq_vec;

  igb_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hw_req),
    .q   (sync_vec)
  );

  assign pend_vec = sync_vec | frc_vec;
  assign fiq_stat = pend_vec & en_vec[TGT_CPU] & cls_vec[TGT_CPU];

  igb_regs #(.W(NUM_SRC), .NT(NT)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .fiq_stat (fiq_stat),
    .prdata   (prdata),
    .frc_q    (frc_vec),
    .en_q     (en_vec),
    .cls_q    (cls_vec)
  );

  igb_route #(.W(NUM_SRC), .NT(NT)) u_route (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_vec),
    .en_q  (en_vec),
    .cls_q (cls_vec),
    .irq_o (irq_vec),
    .fiq_o (fiq_vec)
  );

  assign cpu_irq = irq_vec[TGT_CPU];
  assign cpu_fiq = fiq_vec[TGT_CPU];
  assign cop_irq = irq_vec[TGT_COP];
  assign cop_fiq = fiq_vec[TGT_COP];
endmodule

// File: rtl/irq_gate_bank_chk.sv
module irq_gate_bank_chk #(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [7:0]      paddr,
  input logic [W-1:0]    pwdata,
  input logic [W-1:0]    prdata,
  input logic [1:0][W-1:0] en_vec,
  input logic [1:0][W-1:0] cls_vec,
  input logic [W-1:0]    pend_vec,
  input logic            cpu_irq,
  input logic            cpu_fiq,
  input logic            cop_irq,
  input logic            cop_fiq
);
  logic wr_acc, rd_acc;
  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (prdata == '0 && !cpu_irq && !cpu_fiq && !cop_irq && !cop_fiq));

  // R2
  cpu_set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == 8'h24) |=> ((en_vec[0] & $past(pwdata)) == $past(pwdata)));

  // R2
  cpu_clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == 8'h28) |=> ((en_vec[0] & $past(pwdata)) == '0));

  // R3
  cop_clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == 8'h38) |=> ((en_vec[1] & $past(pwdata)) == '0));

  // R9
  readback_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && paddr == 8'h20) |=> $stable(en_vec[0]));

  // R9
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && paddr == 8'h24) |=> (prdata == '0));

  // R10
  prdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(prdata));

  // R7
  cpu_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(en_vec[0] == '0) |-> (!cpu_irq && !cpu_fiq));

  // R5
  cop_class_zero_no_fiq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cls_vec[1] == '0) |-> !cop_fiq);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pend_vec == '0) |-> (!cpu_irq && !cpu_fiq && !cop_irq && !cop_fiq));
endmodule

bind irq_gate_bank irq_gate_bank_chk #(.W(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .en_vec   (en_vec),
  .cls_vec  (cls_vec),
  .pend_vec (pend_vec),
  .cpu_irq  (cpu_irq),
  .cpu_fiq  (cpu_fiq),
  .cop_irq  (cop_irq),
  .cop_fiq  (cop_fiq)
);

// File: tb/irq_gate_bank_tb.sv
`timescale 1ns/1ps
module irq_gate_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] hw_req = '0;
  logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  irq_gate_bank u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .hw_req(hw_req),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq)
  );

  // Behavioural reference model
  logic [31:0] m_cen, m_pen, m_frc, m_ccls, m_pcls, m_rd;
  logic [31:0] sq[$];
  logic        m_ci, m_cf, m_pi, m_pf;

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [31:0] pend);
    case ({a[7:2], 2'b00})
      8'h08:   return pend & m_cen & m_ccls;
      8'h14:   return m_frc;
      8'h20:   return m_cen;
      8'h2C:   return m_ccls;
      8'h30:   return m_pen;
      8'h3C:   return m_pcls;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] pend;
    logic [7:0]  wa;
    if (rst) begin
      m_cen = 0; m_pen = 0; m_frc = 0; m_ccls = 0; m_pcls = 0; m_rd = 0;
      m_ci = 0; m_cf = 0; m_pi = 0; m_pf = 0;
      sq = {32'h0, 32'h0};
    end else begin
      pend = sq[0] | m_frc;
      m_ci = (pend & m_cen & ~m_ccls) != 0;
      m_cf = (pend & m_cen & m_ccls) != 0;
      m_pi = (pend & m_pen & ~m_pcls) != 0;
      m_pf = (pend & m_pen & m_pcls) != 0;
      if (psel && penable && !pwrite) m_rd = model_read(paddr, pend);
      if (psel && penable && pwrite) begin
        wa = {paddr[7:2], 2'b00};
        case (wa)
          8'h18: m_frc = m_frc | pwdata;
          8'h1C: m_frc = m_frc & ~pwdata;
          8'h24: m_cen = m_cen | pwdata;
          8'h28: m_cen = m_cen & ~pwdata;
          8'h2C: m_ccls = pwdata;
          8'h34: m_pen = m_pen | pwdata;
          8'h38: m_pen = m_pen & ~pwdata;
          8'h3C: m_pcls = pwdata;
          default: ;
        endcase
      end
      void'(sq.pop_front());
      sq.push_back(hw_req);
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (prdata !== m_rd || cpu_irq !== m_ci || cpu_fiq !== m_cf ||
          cop_irq !== m_pi || cop_fiq !== m_pf) begin
        failures++;
        $display("FAIL %s model: actual prdata=%h irq/fiq=%b%b%b%b expected prdata=%h irq/fiq=%b%b%b%b",
                 phase, prdata, cpu_irq, cpu_fiq, cop_irq, cop_fiq,
                 m_rd, m_ci, m_cf, m_pi, m_pf);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); #1;
    penable = 1;
    @(negedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); #1;
    penable = 1;
    @(negedge clk);
    d = prdata;
    #1;
    psel = 0; penable = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] saved;
    repeat (3) @(negedge clk);
    // R1: outputs and readable words zero after reset
    chk("R1 outputs", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
    chk("R1 prdata", prdata, 32'h0);
    #1 rst = 0;
    phase = "R1";
    expect_rd("R1 cpu mask", 8'h20, 32'h0);
    expect_rd("R1 cop mask", 8'h30, 32'h0);
    expect_rd("R1 force", 8'h14, 32'h0);
    expect_rd("R1 class", 8'h2C, 32'h0);

    phase = "R2";
    bus_wr(8'h24, 32'hA5A5_0F0F);
    expect_rd("R2 set", 8'h20, 32'hA5A5_0F0F);
    bus_wr(8'h24, 32'h0000_F000);
    expect_rd("R2 set keeps", 8'h20, 32'hA5A5_FF0F);
    bus_wr(8'h28, 32'h0000_0F0F);
    expect_rd("R2 clear", 8'h20, 32'hA5A5_F000);

    phase = "R9";
    bus_wr(8'h20, 32'hFFFF_FFFF);
    expect_rd("R9 direct write ignored", 8'h20, 32'hA5A5_F000);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    expect_rd("R9 alias read", 8'h24, 32'h0);
    expect_rd("R9 undefined read", 8'h50, 32'h0);
    expect_rd("R9 after undefined write", 8'h2C, 32'h0);

    phase = "R3";
    bus_wr(8'h34, 32'h0000_00FF);
    bus_wr(8'h38, 32'h0000_000F);
    expect_rd("R3 cop mask", 8'h30, 32'h0000_00F0);

    phase = "R5";
    bus_wr(8'h2C, 32'h0000_F0F0);
    bus_wr(8'h3C, 32'h0000_00C0);
    expect_rd("R5 cpu class", 8'h2C, 32'h0000_F0F0);
    expect_rd("R5 cop class", 8'h3C, 32'h0000_00C0);
    chk("R7 idle", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);

    phase = "R4";
    bus_wr(8'h18, 32'h0000_1000);
    wait_cyc(2);
    chk("R4 forced fiq", {30'h0, cpu_irq, cpu_fiq}, 32'h1);
    chk("R7 cop untouched", {30'h0, cop_irq, cop_fiq}, 32'h0);
    expect_rd("R4 force read", 8'h14, 32'h0000_1000);
    phase = "R8";
    expect_rd("R8 fiq status", 8'h08, 32'h0000_1000);
    phase = "R10";
    wait_cyc(3);
    chk("R10 prdata held", prdata, 32'h0000_1000);
    phase = "R4";
    bus_wr(8'h1C, 32'h0000_1000);
    wait_cyc(2);
    chk("R4 withdrawn", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
    bus_wr(8'h14, 32'hFFFF_FFFF);
    expect_rd("R9 force readback write ignored", 8'h14, 32'h0);

    // R6: synchroniser latency; bit 6 -> cop fiq, bit 4 -> cop irq
    phase = "R6";
    @(negedge clk); #1 hw_req = 32'h0000_0050;
    @(negedge clk);
    chk("R6 edge1", {30'h0, cop_irq, cop_fiq}, 32'h0);
    @(negedge clk);
    chk("R6 edge2", {30'h0, cop_irq, cop_fiq}, 32'h0);
    @(negedge clk);
    chk("R6 edge3", {30'h0, cop_irq, cop_fiq}, 32'h3);
    #1 hw_req = 32'h0001_0000; // CPU irq class, cop masked
    phase = "R7";
    wait_cyc(4);
    chk("R7 cpu irq", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h8);
    #1 hw_req = 32'h0001_2040;
    wait_cyc(4);
    chk("R7 mixed", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'hD);
    phase = "R8";
    expect_rd("R8 status from hw", 8'h08, 32'h0000_2000);

    phase = "R11";
    bus_rd(8'h20, saved);
    bus_wr(8'h28, 32'hFFFF_FFFF);
    expect_rd("R11 clear all", 8'h20, 32'h0);
    wait_cyc(1);
    chk("R11 cpu quiet", {30'h0, cpu_irq, cpu_fiq}, 32'h0);
    bus_wr(8'h24, saved);
    expect_rd("R11 restore", 8'h20, 32'hA5A5_F000);
    wait_cyc(1);
    chk("R11 cpu back", {30'h0, cpu_irq, cpu_fiq}, 32'h3);

    #1 hw_req = 32'h0;
    wait_cyc(5);
    phase = "R1";
    #1 rst = 1;
    wait_cyc(2);
    chk("R1 reset again", {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, 32'h0);
    #1 rst = 0;
    expect_rd("R1 mask after reset", 8'h20, 32'h0);
    finish_run();
  end
endmodule